// File: doc/BRIEF.md
# Paged ROM Socket Select Decoder

This block sits on a processor expansion bus beside twelve external ROM sockets. It watches processor writes to a single paging register address and decides which socket, if any, answers reads in the 16 KB paged window from 8000h to BFFFh. Sockets fall into two banks. Four upper sockets take numbers 12 to 15 and are chosen directly. Eight lower sockets take numbers 0 to 7 and are chosen only after the host's own language ROM has been paged out. Numbers 8 to 11 belong to ROMs inside the host. When one of them is chosen, the block releases every external select.

A write is taken when the processor clock phase input falls while the write strobe is high and the address matches. All inputs are sampled on a faster system clock, and the falling phase edge is found there. Upper sockets hold the highest numbers, so a start-up scan that runs from 15 down to 0 reaches them before the host's language ROM.

The controller has three named states. HOST is the reset state: a host ROM owns the window and the lower bank is locked. UPPER means an upper socket is selected. LOWER means a lower socket is selected. Its transitions are the following. UPPER_PICK is a 0000_11xx write, which moves any state to UPPER. HOST_PICK is a 0000_10xx write, which moves any state to HOST. LOWER_PICK is a 0000_0xxx write, which moves UPPER or LOWER to LOWER and leaves HOST where it is. Any other write holds the current state.

Top module: `swp_page_decoder`

## Requirements
- R1: After reset, no chip select is active, and the controller is in HOST with the lower bank locked.
- R2: A write is taken only when its address equals the paging register address, FE05h by default. Writes to every other address leave the selection unchanged.
- R3: A taken write of the form 0000_11xx selects upper socket 12+xx, which drives sel_hi bit xx. It also unlocks the lower bank.
- R4: A taken write of the form 0000_10xx (host numbers 8 to 11) deactivates every external select and locks the lower bank again.
- R5: A taken write of the form 0000_0xxx selects lower socket xxx (sel_lo bit xxx) only when the lower bank is unlocked. While the bank is locked, the selection does not change.
- R6: A write whose upper four data bits are not all zero is ignored.
- R7: A chip select is active only while rd is high and addr[15:14] is 2'b10. At most one of the twelve selects is active at any time.
- R8: A write is taken on the falling edge of phi while wr is high. A write strobe held with no phi fall has no effect.
- R9: Once the bank is unlocked, successive 0000_0xxx writes move between lower sockets without a further upper-bank write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all bus signals |
| rst_n | input | 1 | Active-low synchronous reset |
| phi | input | 1 | Processor clock phase; its falling edge ends a bus cycle |
| addr | input | 16 | Processor address bus |
| data | input | 8 | Processor data bus |
| wr | input | 1 | Write strobe, high for a write cycle |
| rd | input | 1 | Read strobe, high for a read cycle |
| sel_lo | output | 8 | One-hot selects for lower sockets 0 to 7 |
| sel_hi | output | 4 | One-hot selects for upper sockets 12 to 15 |

## Verification
The bench builds the decoder with its default values: a 16-bit address, the register at FE05h, a 3-bit lower socket field and a 2-bit upper socket field. With these values all twelve sockets, all four host numbers and every data byte can be reached in a few hundred writes. The random writes mostly hit the paging address with in-range values, and mix in stray addresses, non-zero upper nibbles and strobes with no phase edge. This brings out the locked-bank case and each state transition many times. The directed cases cover reset, the locked lower bank, each edge of the window, and a write with no phase edge.

// File: rtl/swp_pkg.sv
package swp_pkg;
    // Field widths of the paging value; socket counts derive from them
    localparam int LO_BITS  = 3;
    localparam int HI_BITS  = 2;
    localparam int LO_COUNT = 1 << LO_BITS;
    localparam int HI_COUNT = 1 << HI_BITS;

    typedef enum logic [1:0] {
        PG_HOST  = 2'd0,
        PG_UPPER = 2'd1,
        PG_LOWER = 2'd2
    } pg_state_t;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_HOST  = 2'd1,
        CMD_UPPER = 2'd2,
        CMD_LOWER = 2'd3
    } pg_cmd_t;
endpackage

// File: rtl/swp_wr_decode.sv
module swp_wr_decode
    import swp_pkg::*;
#(
    parameter int              ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFE05
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               phi,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [7:0]         data,
    input  logic               wr,
    output pg_cmd_t            cmd,
    output logic [LO_BITS-1:0] num
);
    logic phi_d;
    logic phi_fall;
    logic hit;

    always_ff @(posedge clk) begin
        if (!rst_n) phi_d <= 1'b0;
        else        phi_d <= phi;
    end

    assign phi_fall = phi_d & ~phi;
    assign hit      = phi_fall & wr & (addr == REG_ADDR) & (data[7:4] == 4'h0);
    assign num      = data[LO_BITS-1:0];

    // Bit 3 clear: lower bank; bits 3:2 = 11: upper bank; 10: host numbers
    always_comb begin
        if (!hit)         cmd = CMD_NONE;
        else if (!data[3]) cmd = CMD_LOWER;
        else if (data[2])  cmd = CMD_UPPER;
        else               cmd = CMD_HOST;
    end
endmodule

// File: rtl/swp_page_fsm.sv
module swp_page_fsm
    import swp_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  pg_cmd_t            cmd,
    input  logic [LO_BITS-1:0] num,
    output logic               lo_en,
    output logic               hi_en,
    output logic [LO_BITS-1:0] sock
);
    pg_state_t          state, state_nx;
    logic [LO_BITS-1:0] sock_nx;

    always_comb begin
        state_nx = state;
        sock_nx  = sock;
        unique case (state)
            PG_HOST: begin
                if (cmd == CMD_UPPER) begin
                    state_nx = PG_UPPER;
                    sock_nx  = LO_BITS'(num[HI_BITS-1:0]);
                end
            end
            PG_UPPER, PG_LOWER: begin
                case (cmd)
                    CMD_UPPER: begin
                        state_nx = PG_UPPER;
                        sock_nx  = LO_BITS'(num[HI_BITS-1:0]);
                    end
                    CMD_HOST:  state_nx = PG_HOST;
                    CMD_LOWER: begin
                        state_nx = PG_LOWER;
                        sock_nx  = num;
                    end
                    default: ;
                endcase
            end
            default: state_nx = PG_HOST;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= PG_HOST;
            sock  <= '0;
        end else begin
            state <= state_nx;
            sock  <= sock_nx;
        end
    end

    always_comb begin
        lo_en = (state == PG_LOWER);
        hi_en = (state == PG_UPPER);
    end

    // R3
    upper_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_UPPER |=> state == PG_UPPER && sock == LO_BITS'($past(num[HI_BITS-1:0])));
    // R4
    host_pick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_HOST |=> state == PG_HOST);
    // R5
    locked_lower_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_LOWER && state == PG_HOST) |=> state == PG_HOST);
    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_NONE |=> $stable(state) && $stable(sock));
endmodule

// File: rtl/swp_cs_gen.sv
module swp_cs_gen
    import swp_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic               lo_en,
    input  logic               hi_en,
    input  logic [LO_BITS-1:0] sock,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               rd,
    output logic [LO_COUNT-1:0] sel_lo,
    output logic [HI_COUNT-1:0] sel_hi
);
    logic in_win;
    assign in_win = rd & (addr[ADDR_W-1:ADDR_W-2] == 2'b10);

    for (genvar i = 0; i < LO_COUNT; i++) begin : g_lo
        assign sel_lo[i] = in_win & lo_en & (sock == LO_BITS'(i));
    end
    for (genvar j = 0; j < HI_COUNT; j++) begin : g_hi
        assign sel_hi[j] = in_win & hi_en & (sock[HI_BITS-1:0] == HI_BITS'(j));
    end

    // R7
    one_socket_chk: assert final ($onehot0({sel_hi, sel_lo}));
endmodule

// File: rtl/swp_page_decoder.sv
module swp_page_decoder
    import swp_pkg::*;
#(
    parameter int                ADDR_W   = 16,
    parameter logic [ADDR_W-1:0] REG_ADDR = 16'hFE05
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                phi,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [7:0]          data,
    input  logic                wr,
    input  logic                rd,
    output logic [LO_COUNT-1:0] sel_lo,
    output logic [HI_COUNT-1:0] sel_hi
);
    pg_cmd_t            cmd;
    logic [LO_BITS-1:0] num;
    logic               lo_en;
    logic               hi_en;
    logic [LO_BITS-1:0] sock;

    swp_wr_decode #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) i_dec (
        .clk(clk), .rst_n(rst_n), .phi(phi), .addr(addr),
        .data(data), .wr(wr), .cmd(cmd), .num(num)
    );

    swp_page_fsm i_fsm (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .num(num),
        .lo_en(lo_en), .hi_en(hi_en), .sock(sock)
    );

    swp_cs_gen #(.ADDR_W(ADDR_W)) i_cs (
        .lo_en(lo_en), .hi_en(hi_en), .sock(sock), .addr(addr),
        .rd(rd), .sel_lo(sel_lo), .sel_hi(sel_hi)
    );

    // R7
    window_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|{sel_hi, sel_lo}) |-> rd && addr[ADDR_W-1:ADDR_W-2] == 2'b10);
    // R8
    no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(phi) || phi) |=> $stable({sel_hi, sel_lo}) || !$stable(addr) || !$stable(rd));
endmodule

// File: tb/test_swp_page_decoder.sv
`timescale 1ns/1ps
module test_swp_page_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phi = 1'b1;
    logic [15:0] addr = 16'h0000;
    logic [7:0]  data = 8'h00;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [7:0]  sel_lo;
    logic [3:0]  sel_hi;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // model: 0 host (locked), 1 upper, 2 lower
    int m_state = 0;
    int m_sock  = 0;

    always #5 clk = ~clk;

    swp_page_decoder i_swp_page_decoder (
        .clk(clk), .rst_n(rst_n), .phi(phi), .addr(addr), .data(data),
        .wr(wr), .rd(rd), .sel_lo(sel_lo), .sel_hi(sel_hi)
    );

    function automatic logic [11:0] expect_sel(input logic [15:0] a, input logic r);
        logic [11:0] v = '0;
        if (r && a[15:14] == 2'b10) begin
            if (m_state == 1) v[8 + m_sock] = 1'b1;
            if (m_state == 2) v[m_sock] = 1'b1;
        end
        return v;
    endfunction

    task automatic model_write(input logic [15:0] a, input logic [7:0] d);
        if (a != 16'hFE05 || d[7:4] != 4'h0) return;
        if (d[3:2] == 2'b11) begin m_state = 1; m_sock = int'(d[1:0]); end
        else if (d[3:2] == 2'b10) m_state = 0;
        else if (m_state != 0) begin m_state = 2; m_sock = int'(d[2:0]); end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input bit fall);
        @(negedge clk);
        addr = a; data = d; wr = 1'b1; phi = 1'b1;
        repeat (2) @(negedge clk);
        if (fall) phi = 1'b0;
        @(negedge clk);
        wr = 1'b0;
        @(negedge clk);
        phi = 1'b1;
        if (fall) model_write(a, d);
    endtask

    task automatic check_read(input logic [15:0] a, input logic r, input string tag);
        logic [11:0] exp_v;
        @(negedge clk);
        addr = a; rd = r;
        #2;
        exp_v = expect_sel(a, r);
        checks++;
        if ({sel_hi, sel_lo} !== exp_v) begin
            errors++;
            $display("FAIL %s: addr=%04h rd=%0b actual=%03h expected=%03h",
                     tag, a, r, {sel_hi, sel_lo}, exp_v);
        end
        @(negedge clk);
        rd = 1'b0;
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int seed_dummy;
        seed_dummy = $urandom(32'h5EED_0042);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_read(16'h8000, 1'b1, "R1 reset");
        // R5 / R1 locked after reset
        bus_write(16'hFE05, 8'h03, 1);
        check_read(16'h9000, 1'b1, "R5 locked after reset R1");
        // R3 upper socket 14
        bus_write(16'hFE05, 8'h0E, 1);
        check_read(16'hA123, 1'b1, "R3 upper 14");
        // R7 window edges and read strobe
        check_read(16'hA123, 1'b0, "R7 no read strobe");
        check_read(16'hC000, 1'b1, "R7 above window");
        check_read(16'h7FFF, 1'b1, "R7 below window");
        check_read(16'hBFFF, 1'b1, "R7 top of window");
        // R5 lower socket after unlock
        bus_write(16'hFE05, 8'h05, 1);
        check_read(16'h8000, 1'b1, "R5 lower 5");
        // R9 lower to lower
        bus_write(16'hFE05, 8'h01, 1);
        check_read(16'h8000, 1'b1, "R9 lower 1");
        // R6 upper nibble set
        bus_write(16'hFE05, 8'h2C, 1);
        check_read(16'h8000, 1'b1, "R6 nibble ignored");
        // R2 other address
        bus_write(16'hFE04, 8'h0C, 1);
        check_read(16'h8000, 1'b1, "R2 other address");
        // R8 no phase edge
        bus_write(16'hFE05, 8'h0D, 0);
        check_read(16'h8000, 1'b1, "R8 no edge");
        // R4 host number and relock
        bus_write(16'hFE05, 8'h0A, 1);
        check_read(16'h8000, 1'b1, "R4 host 10");
        bus_write(16'hFE05, 8'h02, 1);
        check_read(16'h8000, 1'b1, "R4 relocked");
        bus_write(16'hFE05, 8'h0C, 1);
        bus_write(16'hFE05, 8'h07, 1);
        check_read(16'hB000, 1'b1, "R5 unlock then lower 7");
        // R1 reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        m_state = 0; m_sock = 0;
        check_read(16'h8000, 1'b1, "R1 reset clears");

        for (int k = 0; k < 300; k++) begin
            logic [15:0] a;
            logic [7:0]  d;
            bit          f;
            a = ($urandom % 10 < 8) ? 16'hFE05 : 16'($urandom);
            d = ($urandom % 10 < 7) ? 8'($urandom % 16) : 8'($urandom);
            f = ($urandom % 10 < 9);
            bus_write(a, d, f);
            check_read({2'b10, 14'($urandom)}, 1'b1, "R3 R4 R5 R9 random");
            if (k % 5 == 0)
                check_read(16'($urandom), 1'($urandom), "R7 random read");
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule